// File: doc/BRIEF.md
# Subcommand Mailbox Transfer Controller

This block is a register-mapped mailbox that sits behind a byte-wide host register port. The host selects a 16-bit subcommand address through two address registers. By default the block treats each new address as a read request. It copies 32 bytes from an internal byte memory into a transfer buffer and places an inverted modulo-256 checksum next to the buffer. Reading the length register steps the address forward by one buffer and refills the buffer, so the host can walk a long region of memory with plain register reads.

To write memory, the host fills the buffer, writes a checksum, and then writes the length register. The block checks the length and the checksum before it copies any byte into memory. A mismatch or an illegal length sets a sticky error flag and leaves memory untouched.

While the sequencer is filling, verifying or committing, a busy output asks the bus side to stretch the transfer. Host accesses made during that time have no effect. Any address in the command page fires a single-cycle trigger with the address, but only when the host writes that address. An address reached by stepping never fires it.

Top module: `mbox_xfer_ctrl`

## Requirements
- R1: Register 0x3E holds the low byte and 0x3F the high byte of the subcommand address. Reading either register returns the current address byte, including after an auto-increment.
- R2: A host write to 0x3F starts a fill. `host_busy` rises at the next clock edge. When it falls, registers 0x40..0x5F hold memory bytes address+0 .. address+31, and 0x61 reads 0x24.
- R3: After a fill, register 0x60 holds the bitwise inverse of the 8-bit sum of the address low byte, the address high byte and all 32 buffer bytes.
- R4: A host read of 0x61 returns the stored length. After that, the subcommand address has grown by 0x0020 and the buffer is refilled from the new address.
- R5: A host write of L to 0x61, with 4 <= L <= 0x24, compares register 0x60 with the inverted 8-bit sum of both address bytes and buffer bytes 0..L-5. On a match, those L-4 bytes are written to memory at address+0 and onward. No other memory byte changes, and `xfer_err` stays 0.
- R6: If that comparison fails, memory is not written and `xfer_err` becomes 1.
- R7: A length below 4 or above 0x24 written to 0x61 starts no transfer. `xfer_err` becomes 1 at the next edge, and `host_busy` stays 0.
- R8: `xfer_err` is sticky. It returns to 0 at the edge after a host write to 0x3E or 0x3F.
- R9: A host write to 0x3F whose data equals `CMD_PAGE` (default 0x00) produces a one-cycle `cmd_fire` at the next edge, with `cmd_code` equal to the full written address. An address reached by auto-increment never produces `cmd_fire`.
- R10: While `host_busy` is 1, host writes and the length-read side effect are ignored. Registers written during busy keep the values the sequencer gives them.
- R11: After reset, `host_busy`, `xfer_err` and `cmd_fire` are 0, and registers 0x3E, 0x3F, 0x60 and 0x61 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 7 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects only; data is combinational) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read data for `host_addr` |
| host_busy | output | 1 | Sequencer active; stretch requests to the host |
| mem_addr | output | 16 | Data memory byte address |
| mem_we | output | 1 | Data memory write enable |
| mem_wdata | output | 8 | Data memory write data |
| mem_rdata | input | 8 | Data memory read data, one cycle after address |
| cmd_fire | output | 1 | One-cycle trigger for a command-page address write |
| cmd_code | output | 16 | Address that accompanies `cmd_fire` |
| xfer_err | output | 1 | Sticky write-transfer error |

## Verification
The assertions watch the rules that hold cycle by cycle. A write to the high address byte must raise busy. A length read must step the address by exactly one buffer. A bad length must set the error without starting the sequencer. An address write must clear the error. The trigger must be a single pulse caused by a high-byte write, and busy-time accesses must not move the address. Only the bench scenarios can show the data content: fill bytes, the fill checksum, committed and rejected writes, the zero-byte transfer, and stepped refills, all compared against a bench memory image.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int          BUF_BYTES   = 32;
    localparam logic [6:0]  REG_ADDR_LO = 7'h3E;
    localparam logic [6:0]  REG_ADDR_HI = 7'h3F;
    localparam logic [7:0]  BUF_BASE    = 8'h40;
    localparam logic [7:0]  LEN_EXTRA   = 8'd4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FILL,
        S_VERIFY,
        S_COMMIT
    } seq_state_e;

    typedef struct packed {
        logic [15:0] base;
        logic [7:0]  expect_chk;
    } job_t;

    function automatic logic [7:0] addr_sum(input logic [15:0] a);
        return a[15:8] + a[7:0];
    endfunction

endpackage

// File: rtl/mbox_buf.sv
module mbox_buf #(
    parameter  int DEPTH = 32,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [IW-1:0] host_widx,
    input  logic [7:0]    host_wdata,
    input  logic          fill_we,
    input  logic [IW-1:0] fill_widx,
    input  logic [7:0]    fill_wdata,
    input  logic [IW-1:0] host_ridx,
    output logic [7:0]    host_rdata,
    input  logic [IW-1:0] seq_ridx,
    output logic [7:0]    seq_rdata
);
    logic [7:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (fill_we && fill_widx == IW'(g))
                slot_q[g] <= fill_wdata;
            else if (host_we && host_widx == IW'(g))
                slot_q[g] <= host_wdata;
        end
    end

    assign host_rdata = slot_q[host_ridx];
    assign seq_rdata  = slot_q[seq_ridx];

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import mbox_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fill_go,
    input  logic          verify_go,
    input  job_t          job_in,
    input  logic [CW-1:0] count_in,
    output logic          busy,
    output logic [15:0]   mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          buf_we,
    output logic [IW-1:0] buf_widx,
    output logic [7:0]    buf_wdata,
    output logic [IW-1:0] buf_ridx,
    input  logic [7:0]    buf_rdata,
    output logic          chk_we,
    output logic [7:0]    chk_val,
    output logic          verify_fail
);
    seq_state_e    state_q;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] prev_idx;
    logic [7:0]    sum_q;
    job_t          job_q;
    logic          at_end;

    assign at_end   = (idx_q == cnt_q);
    assign prev_idx = idx_q - CW'(1);

    always_comb begin
        busy        = (state_q != S_IDLE);
        mem_addr    = job_q.base + 16'(idx_q);
        mem_we      = (state_q == S_COMMIT) && !at_end;
        mem_wdata   = buf_rdata;
        buf_ridx    = idx_q[IW-1:0];
        buf_we      = (state_q == S_FILL) && (idx_q != '0);
        buf_widx    = prev_idx[IW-1:0];
        buf_wdata   = mem_rdata;
        chk_we      = (state_q == S_FILL) && at_end;
        chk_val     = ~(sum_q + mem_rdata);
        verify_fail = (state_q == S_VERIFY) && at_end && (~sum_q != job_q.expect_chk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            sum_q   <= '0;
            job_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (fill_go || verify_go) begin
                        state_q <= fill_go ? S_FILL : S_VERIFY;
                        job_q   <= job_in;
                        cnt_q   <= count_in;
                        idx_q   <= '0;
                        sum_q   <= addr_sum(job_in.base);
                    end
                end
                S_FILL: begin
                    if (at_end) begin
                        state_q <= S_IDLE;
                    end else begin
                        idx_q <= idx_q + CW'(1);
                        if (idx_q != '0)
                            sum_q <= sum_q + mem_rdata;
                    end
                end
                S_VERIFY: begin
                    if (at_end) begin
                        idx_q   <= '0;
                        state_q <= (~sum_q == job_q.expect_chk) ? S_COMMIT : S_IDLE;
                    end else begin
                        sum_q <= sum_q + buf_rdata;
                        idx_q <= idx_q + CW'(1);
                    end
                end
                S_COMMIT: begin
                    if (at_end)
                        state_q <= S_IDLE;
                    else
                        idx_q <= idx_q + CW'(1);
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Writes reach memory only after a verify pass: the previous cycle was verify or commit.
    p_commit_after_verify_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(state_q) == S_VERIFY || $past(state_q) == S_COMMIT));

    // A failed comparison returns to idle without touching memory.
    p_fail_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        verify_fail |=> (!mem_we && !busy));

endmodule

// File: rtl/mbox_xfer_ctrl.sv
module mbox_xfer_ctrl
    import mbox_pkg::*;
#(
    parameter int         BUF_BYTES = mbox_pkg::BUF_BYTES,
    parameter logic [7:0] CMD_PAGE  = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        host_busy,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        cmd_fire,
    output logic [15:0] cmd_code,
    output logic        xfer_err
);
    localparam int         IW       = $clog2(BUF_BYTES);
    localparam int         CW       = IW + 1;
    localparam logic [7:0] BUF_END  = BUF_BASE + 8'(BUF_BYTES);
    localparam logic [6:0] REG_CHK  = BUF_END[6:0];
    localparam logic [6:0] REG_LEN  = REG_CHK + 7'd1;
    localparam logic [7:0] LEN_FULL = 8'(BUF_BYTES) + LEN_EXTRA;

    logic [15:0] sc_addr_q, next_addr;
    logic [7:0]  chk_q, len_q;
    logic        err_q, fire_q;
    logic [15:0] code_q;

    logic [7:0]    addr8, buf_off;
    logic          is_buf, acc_wr, acc_rd;
    logic          wr_lo, wr_hi, wr_buf, wr_chk, wr_len, rd_len, len_ok;
    logic          fill_go, verify_go;
    job_t          job;
    logic [CW-1:0] job_count;

    logic          seq_busy, buf_we, chk_we, verify_fail;
    logic [IW-1:0] buf_widx, seq_ridx;
    logic [7:0]    buf_wdata, chk_val, seq_rdata, buf_host_rdata;

    always_comb begin
        addr8     = {1'b0, host_addr};
        buf_off   = addr8 - BUF_BASE;
        is_buf    = (addr8 >= BUF_BASE) && (addr8 < BUF_END);
        acc_wr    = host_wr && !seq_busy;
        acc_rd    = host_rd && !host_wr && !seq_busy;
        wr_lo     = acc_wr && (host_addr == REG_ADDR_LO);
        wr_hi     = acc_wr && (host_addr == REG_ADDR_HI);
        wr_buf    = acc_wr && is_buf;
        wr_chk    = acc_wr && (host_addr == REG_CHK);
        wr_len    = acc_wr && (host_addr == REG_LEN);
        rd_len    = acc_rd && (host_addr == REG_LEN);
        len_ok    = (host_wdata >= LEN_EXTRA) && (host_wdata <= LEN_FULL);
        next_addr = sc_addr_q + 16'(BUF_BYTES);
        fill_go   = wr_hi || rd_len;
        verify_go = wr_len && len_ok;
        job.expect_chk = chk_q;
        if (wr_hi)
            job.base = {host_wdata, sc_addr_q[7:0]};
        else if (rd_len)
            job.base = next_addr;
        else
            job.base = sc_addr_q;
        job_count = fill_go ? CW'(BUF_BYTES) : CW'(host_wdata - LEN_EXTRA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_addr_q <= '0;
            chk_q     <= '0;
            len_q     <= '0;
            err_q     <= 1'b0;
            fire_q    <= 1'b0;
            code_q    <= '0;
        end else begin
            fire_q <= wr_hi && (host_wdata == CMD_PAGE);
            if (wr_hi)
                code_q <= {host_wdata, sc_addr_q[7:0]};

            if (wr_lo)
                sc_addr_q[7:0] <= host_wdata;
            else if (wr_hi)
                sc_addr_q[15:8] <= host_wdata;
            else if (rd_len)
                sc_addr_q <= next_addr;

            if (wr_len)
                len_q <= host_wdata;
            else if (fill_go)
                len_q <= LEN_FULL;

            if (chk_we)
                chk_q <= chk_val;
            else if (wr_chk)
                chk_q <= host_wdata;

            if (wr_lo || wr_hi)
                err_q <= 1'b0;
            else if ((wr_len && !len_ok) || verify_fail)
                err_q <= 1'b1;
        end
    end

    mbox_buf #(.DEPTH(BUF_BYTES)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .host_we    (wr_buf),
        .host_widx  (buf_off[IW-1:0]),
        .host_wdata (host_wdata),
        .fill_we    (buf_we),
        .fill_widx  (buf_widx),
        .fill_wdata (buf_wdata),
        .host_ridx  (buf_off[IW-1:0]),
        .host_rdata (buf_host_rdata),
        .seq_ridx   (seq_ridx),
        .seq_rdata  (seq_rdata)
    );

    mbox_seq #(.DEPTH(BUF_BYTES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .fill_go     (fill_go),
        .verify_go   (verify_go),
        .job_in      (job),
        .count_in    (job_count),
        .busy        (seq_busy),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .buf_we      (buf_we),
        .buf_widx    (buf_widx),
        .buf_wdata   (buf_wdata),
        .buf_ridx    (seq_ridx),
        .buf_rdata   (seq_rdata),
        .chk_we      (chk_we),
        .chk_val     (chk_val),
        .verify_fail (verify_fail)
    );

    always_comb begin
        host_rdata = '0;
        if (is_buf)
            host_rdata = buf_host_rdata;
        else if (host_addr == REG_ADDR_LO)
            host_rdata = sc_addr_q[7:0];
        else if (host_addr == REG_ADDR_HI)
            host_rdata = sc_addr_q[15:8];
        else if (host_addr == REG_CHK)
            host_rdata = chk_q;
        else if (host_addr == REG_LEN)
            host_rdata = len_q;
    end

    assign host_busy = seq_busy;
    assign cmd_fire  = fire_q;
    assign cmd_code  = code_q;
    assign xfer_err  = err_q;

    p_fill_busy_r2: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> host_busy);

    p_step_addr_r4: assert property (@(posedge clk) disable iff (rst)
        rd_len |=> (sc_addr_q == $past(sc_addr_q) + 16'(BUF_BYTES)));

    p_bad_len_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_len && !len_ok) |=> (xfer_err && !host_busy));

    p_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_lo || wr_hi) |=> !xfer_err);

    p_fire_cause_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_fire |-> $past(host_wr && host_addr == REG_ADDR_HI));

    p_fire_single_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_fire |=> !cmd_fire);

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (host_busy && (host_wr || host_rd)) |=> $stable(sc_addr_q));

endmodule

// File: tb/sim_mbox_xfer_ctrl.sv
module sim_mbox_xfer_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_SIZE   = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_busy;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        cmd_fire;
    logic [15:0] cmd_code;
    logic        xfer_err;

    logic [7:0]  mem_arr [MEM_SIZE];
    logic [7:0]  ref_arr [MEM_SIZE];
    int          n_chk = 0, n_fail = 0, fire_cnt = 0;
    logic [15:0] last_code = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_xfer_ctrl u0 (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_busy(host_busy), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cmd_fire(cmd_fire),
        .cmd_code(cmd_code), .xfer_err(xfer_err)
    );

    always @(posedge clk) begin
        mem_rdata <= mem_arr[mem_addr[9:0]];
        if (mem_we) mem_arr[mem_addr[9:0]] <= mem_wdata;
        if (cmd_fire) begin
            fire_cnt  <= fire_cnt + 1;
            last_code <= cmd_code;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish act=hung exp=done");
        finish_run();
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        while (host_busy) @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (host_busy) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_fill_chk(input logic [15:0] a);
        logic [7:0] s = a[15:8] + a[7:0];
        for (int i = 0; i < 32; i++) s = s + ref_arr[(int'(a) + i) % MEM_SIZE];
        return ~s;
    endfunction

    task automatic set_addr(input logic [15:0] a);
        wr(7'h3E, a[7:0]);
        wr(7'h3F, a[15:8]);
    endtask

    task automatic check_fill(input logic [15:0] a, input string tag);
        logic [7:0] d;
        int bad = 0;
        logic [7:0] first_act = '0, first_exp = '0;
        for (int i = 0; i < 32; i++) begin
            rd(7'(8'h40 + 8'(i)), d);
            if (d !== ref_arr[(int'(a) + i) % MEM_SIZE] && bad == 0) begin
                first_act = d; first_exp = ref_arr[(int'(a) + i) % MEM_SIZE];
            end
            if (d !== ref_arr[(int'(a) + i) % MEM_SIZE]) bad++;
        end
        check({tag, " buffer"}, {24'd0, first_act}, {24'd0, first_exp});
        rd(7'h60, d);
        check("R3 fill checksum", {24'd0, d}, {24'd0, exp_fill_chk(a)});
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input logic corrupt);
        logic [7:0] data [32];
        logic [7:0] s;
        set_addr(a);
        wait_idle();
        s = a[15:8] + a[7:0];
        for (int i = 0; i < n; i++) begin
            data[i] = 8'($urandom);
            s = s + data[i];
            wr(7'(8'h40 + 8'(i)), data[i]);
        end
        wr(7'h60, corrupt ? ~s ^ 8'h01 : ~s);
        wr(7'h61, 8'(n + 4));
        wait_idle();
        if (!corrupt)
            for (int i = 0; i < n; i++) ref_arr[(int'(a) + i) % MEM_SIZE] = data[i];
    endtask

    initial begin
        logic [7:0]  d;
        logic [15:0] a;
        int          f0;
        void'($urandom(32'd1234));
        for (int i = 0; i < MEM_SIZE; i++) begin
            mem_arr[i] = 8'((i * 37 + 11) ^ (i >> 3));
            ref_arr[i] = mem_arr[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);

        check("R11 busy after reset", {31'd0, host_busy}, 0);
        check("R11 err after reset", {31'd0, xfer_err}, 0);
        check("R11 fire after reset", {31'd0, cmd_fire}, 0);
        host_addr = 7'h3E; #1 check("R11 addr lo reset", {24'd0, host_rdata}, 0);
        host_addr = 7'h3F; #1 check("R11 addr hi reset", {24'd0, host_rdata}, 0);
        host_addr = 7'h60; #1 check("R11 chk reset", {24'd0, host_rdata}, 0);
        host_addr = 7'h61; #1 check("R11 len reset", {24'd0, host_rdata}, 0);

        // Fill at a non-command address
        a = 16'h0123;
        set_addr(a);
        check("R2 busy after high byte write", {31'd0, host_busy}, 1);
        // R10: writes during busy are dropped
        wr(7'h60, 8'h5A);
        wr(7'h3E, 8'hEE);
        wait_idle();
        check_fill(a, "R2 fill");
        rd(7'h3E, d); check("R1 R10 addr lo echo", {24'd0, d}, 32'h23);
        rd(7'h3F, d); check("R1 addr hi echo", {24'd0, d}, 32'h01);

        // Auto-increment chain
        for (int k = 0; k < 3; k++) begin
            rd(7'h61, d); check("R4 length read value", {24'd0, d}, 32'h24);
            a = a + 16'h0020;
            wait_idle();
            rd(7'h3E, d); check("R1 R4 stepped addr lo", {24'd0, d}, {24'd0, a[7:0]});
            rd(7'h3F, d); check("R1 R4 stepped addr hi", {24'd0, d}, {24'd0, a[15:8]});
            check_fill(a, "R4 refill");
        end

        // Random committed writes
        for (int k = 0; k < 6; k++) begin
            a = 16'h0100 + 16'($urandom_range(0, 700));
            do_write(a, (k == 0) ? 32 : int'($urandom_range(1, 31)), 1'b0);
            check("R5 no error on valid write", {31'd0, xfer_err}, 0);
            set_addr(a); wait_idle();
            check_fill(a, "R5 committed");
        end

        // Zero-byte transfer
        a = 16'h0240;
        do_write(a, 0, 1'b0);
        check("R5 length 4 no error", {31'd0, xfer_err}, 0);
        set_addr(a); wait_idle();
        check_fill(a, "R5 length 4 memory unchanged");

        // Bad checksum
        a = 16'h0300;
        do_write(a, 12, 1'b1);
        check("R6 error on mismatch", {31'd0, xfer_err}, 1);
        set_addr(a);
        check("R8 error cleared by address write", {31'd0, xfer_err}, 0);
        wait_idle();
        check_fill(a, "R6 memory unchanged");

        // Illegal lengths
        wr(7'h61, 8'd3);
        check("R7 length 3 error", {31'd0, xfer_err}, 1);
        check("R7 length 3 not busy", {31'd0, host_busy}, 0);
        wr(7'h3E, 8'h00);
        check("R8 error cleared by low write", {31'd0, xfer_err}, 0);
        wr(7'h61, 8'h25);
        check("R7 length 0x25 error", {31'd0, xfer_err}, 1);
        check("R7 length 0x25 not busy", {31'd0, host_busy}, 0);

        // Command-page address
        f0 = fire_cnt;
        set_addr(16'h0005);
        wait_idle();
        check("R9 fire count", fire_cnt - f0, 1);
        check("R9 fire code", {16'd0, last_code}, 32'h0005);
        rd(7'h61, d);
        wait_idle();
        check("R9 no fire on auto-increment", fire_cnt - f0, 1);
        check_fill(16'h0025, "R9 R4 stepped in command page");

        finish_run();
    end
endmodule